// File: doc/BRIEF.md
# Framed SPI Master Peripheral

A register-mapped SPI master for a small controller. Software writes a word into a transmit holding register. When the master and enable bits are both set, the word moves into a shift engine. The engine clocks it out MSB first while it clocks the receive line in, and the received word lands in a read register with a full flag. A 16-bit divider sets the serial clock. Each half period of the serial clock lasts that many system cycles. Word length runs from 1 to 8 bits, and all four polarity/phase combinations are supported.

The slave-select line frames a transfer. It goes active when the first word of a frame enters the shift engine. It stays active across back-to-back words. It is released only when a word marked as end-of-frame has finished. Software marks that word by setting the end-of-frame control bit before the word enters the shift register. The bit is consumed, and cleared by hardware, when that word is loaded.

Register map (8-bit bus, 3-bit address): 0 data, 1 control, 2 word length, 3 status, 4 divider low byte, 5 divider high byte.

Top module: `spi_frame_master`

## Requirements
- R1: After reset the status register (address 3) reads 0x01, the control register (address 1) reads 0x00, the word-length register (address 2) reads 0x00 (meaning 8 bits), slave select `ss_n` is high and `sck` is low.
- R2: While a word shifts, successive `sck` edges are spaced by exactly the divider value (addresses 4/5, low byte first) in system clock cycles, with a divider of 0 acting as 1. The first edge of a word follows the previous one by the same spacing, measured from the start of the word.
- R3: The word-length field (address 2, bits 2:0) selects N = 1..7 bits, and the value 0 selects 8 bits. A word produces exactly 2N `sck` edges.
- R4: Control bit 2 is clock polarity and bit 3 is clock phase. `sck` rests at the polarity level whenever no word is shifting. With phase 0, data is valid before the first edge and is sampled on leading edges. With phase 1, data changes on leading edges and is sampled on trailing edges. A word looped back from `mosi` to `miso` is received unchanged in every mode.
- R5: Only the low N bits of the written word are sent, MSB first. The received word is right-aligned, and the bits above N read as zero.
- R6: Status bit 0 (transmit empty) clears on a write to address 0. It sets again when that word moves into the shift register.
- R7: Status bit 1 (receive full) sets when a word completes. A read of address 0 returns the last received word and clears the bit.
- R8: Status bit 2 (busy) is set while a word is shifting, and `ss_n` is low for all of that time.
- R9: `ss_n` goes low when the first word of a frame is loaded. It stays low across consecutive words that are not end-of-frame.
- R10: Control bit 4 (end of frame) is captured by the next word loaded into the shift register and is cleared by hardware at that moment. `ss_n` rises when that word completes.
- R11: Shifting starts only while both control bit 0 (enable) and bit 1 (master) are set. Otherwise no `sck` edge occurs, `ss_n` stays high and a written word waits in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle; reading address 0 clears receive full |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions assume that bus strobes are single-cycle. They also assume that software does not flip clock polarity or word length while a frame is open, because the serial clock rest level follows the polarity bit directly. The stimulus follows this: it rewrites the configuration only after `ss_n` has risen, and it polls status through reads, which have no side effect. `miso` is tied to `mosi`, so the data received in each mode can be predicted. A bench-side monitor samples `mosi` on the sampling edge of the selected mode and checks that edge against the phase rules independently of the design.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  localparam int REG_W = 8;

  // register addresses
  localparam int A_DATA = 0;
  localparam int A_CTRL = 1;
  localparam int A_LEN  = 2;
  localparam int A_STAT = 3;
  localparam int A_DIVL = 4;
  localparam int A_DIVH = 5;

  // control bits
  localparam int C_EN   = 0;
  localparam int C_MST  = 1;
  localparam int C_CPOL = 2;
  localparam int C_CPHA = 3;
  localparam int C_EOF  = 4;

  // status bits
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_BUSY = 2;

  typedef struct packed {
    logic en;
    logic master;
    logic cpol;
    logic cpha;
  } spi_cfg_t;

endpackage

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
  import spi_fm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              load_ack,
  input  logic              eof_clr,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              busy,
  output spi_cfg_t          cfg,
  output logic [DIV_W-1:0]  brg,
  output logic [LEN_W-1:0]  len_code,
  output logic [WORD_W-1:0] tx_hold,
  output logic              tx_full,
  output logic              eof,
  output logic              rx_full
);

  spi_cfg_t          cfg_q, cfg_d;
  logic [DIV_W-1:0]  brg_q, brg_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] rxd_q, rxd_d;
  logic              txf_q, txf_d;
  logic              eof_q, eof_d;
  logic              rxf_q, rxf_d;

  logic wr_data, wr_ctrl, wr_len, wr_divl, wr_divh, rd_data;

  always_comb begin
    wr_data = bus_wr && (bus_addr == ADDR_W'(A_DATA));
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    wr_len  = bus_wr && (bus_addr == ADDR_W'(A_LEN));
    wr_divl = bus_wr && (bus_addr == ADDR_W'(A_DIVL));
    wr_divh = bus_wr && (bus_addr == ADDR_W'(A_DIVH));
    rd_data = bus_rd && (bus_addr == ADDR_W'(A_DATA));
  end

  // next-state
  always_comb begin
    cfg_d  = cfg_q;
    brg_d  = brg_q;
    len_d  = len_q;
    hold_d = hold_q;
    rxd_d  = rxd_q;
    txf_d  = txf_q;
    eof_d  = eof_q;
    rxf_d  = rxf_q;

    if (wr_ctrl) begin
      cfg_d.en     = bus_wdata[C_EN];
      cfg_d.master = bus_wdata[C_MST];
      cfg_d.cpol   = bus_wdata[C_CPOL];
      cfg_d.cpha   = bus_wdata[C_CPHA];
    end
    if (wr_len)  len_d = bus_wdata[LEN_W-1:0];
    if (wr_divl) brg_d[REG_W-1:0] = bus_wdata;
    if (wr_divh) brg_d[DIV_W-1:REG_W] = bus_wdata[DIV_W-REG_W-1:0];

    if (wr_data) begin
      hold_d = bus_wdata[WORD_W-1:0];
      txf_d  = 1'b1;
    end else if (load_ack) begin
      txf_d  = 1'b0;
    end

    if (wr_ctrl)      eof_d = bus_wdata[C_EOF];
    else if (eof_clr) eof_d = 1'b0;

    if (word_done) begin
      rxd_d = rx_word;
      rxf_d = 1'b1;
    end else if (rd_data) begin
      rxf_d = 1'b0;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      brg_q  <= '0;
      len_q  <= '0;
      hold_q <= '0;
      rxd_q  <= '0;
      txf_q  <= 1'b0;
      eof_q  <= 1'b0;
      rxf_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      brg_q  <= brg_d;
      len_q  <= len_d;
      hold_q <= hold_d;
      rxd_q  <= rxd_d;
      txf_q  <= txf_d;
      eof_q  <= eof_d;
      rxf_q  <= rxf_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_DATA: bus_rdata = REG_W'(rxd_q);
      A_CTRL: begin
        bus_rdata[C_EN]   = cfg_q.en;
        bus_rdata[C_MST]  = cfg_q.master;
        bus_rdata[C_CPOL] = cfg_q.cpol;
        bus_rdata[C_CPHA] = cfg_q.cpha;
        bus_rdata[C_EOF]  = eof_q;
      end
      A_LEN:  bus_rdata = REG_W'(len_q);
      A_STAT: begin
        bus_rdata[S_TXE]  = ~txf_q;
        bus_rdata[S_RXF]  = rxf_q;
        bus_rdata[S_BUSY] = busy;
      end
      A_DIVL: bus_rdata = brg_q[REG_W-1:0];
      A_DIVH: bus_rdata = REG_W'(brg_q[DIV_W-1:REG_W]);
      default: bus_rdata = '0;
    endcase
  end

  assign cfg      = cfg_q;
  assign brg      = brg_q;
  assign len_code = len_q;
  assign tx_hold  = hold_q;
  assign tx_full  = txf_q;
  assign eof      = eof_q;
  assign rx_full  = rxf_q;

endmodule

// File: rtl/spi_fm_baud.sv
module spi_fm_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] brg,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] term;

  always_comb begin
    term  = (brg == '0) ? DIV_W'(1) : brg;
    tick  = run && (cnt_q == term - DIV_W'(1));
    cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_fm_shift.sv
module spi_fm_shift
  import spi_fm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int LEN_W = $clog2(WORD_W),
  localparam int NB_W  = LEN_W + 1,
  localparam int EC_W  = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_cfg_t          cfg,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [WORD_W-1:0] tx_hold,
  input  logic              tx_full,
  input  logic              eof,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              load_ack,
  output logic              eof_clr,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word
);

  logic              busy_q, busy_d;
  logic              ss_q, ss_d;
  logic              sck_q, sck_d;
  logic              mosi_q, mosi_d;
  logic              last_q, last_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [EC_W-1:0]   edge_q, edge_d;
  logic [NB_W-1:0]   nb_q, nb_d;

  logic            go;
  logic [NB_W-1:0] nbits_w;
  logic [EC_W-1:0] last_edge;
  logic            sample_edge;

  always_comb begin
    go          = cfg.en && cfg.master;
    nbits_w     = (len_code == '0) ? NB_W'(WORD_W) : {1'b0, len_code};
    last_edge   = {nb_q, 1'b0} - EC_W'(1);
    // leading edges are even-numbered; phase 0 samples on them
    sample_edge = (~edge_q[0]) ^ cfg.cpha;

    busy_d    = busy_q;
    ss_d      = ss_q;
    sck_d     = sck_q;
    mosi_d    = mosi_q;
    last_d    = last_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    edge_d    = edge_q;
    nb_d      = nb_q;
    load_ack  = 1'b0;
    eof_clr   = 1'b0;
    word_done = 1'b0;

    if (!go) begin
      busy_d = 1'b0;
      ss_d   = 1'b0;
      sck_d  = cfg.cpol;
    end else if (!busy_q) begin
      sck_d = cfg.cpol;
      if (tx_full) begin
        load_ack = 1'b1;
        eof_clr  = eof;
        last_d   = eof;
        busy_d   = 1'b1;
        ss_d     = 1'b1;
        edge_d   = '0;
        nb_d     = nbits_w;
        rx_d     = '0;
        tx_d     = tx_hold << (WORD_W - int'(nbits_w));
        if (!cfg.cpha) begin
          mosi_d = tx_d[WORD_W-1];
          tx_d   = tx_d << 1;
        end
      end
    end else if (tick) begin
      sck_d = ~sck_q;
      if (sample_edge) begin
        rx_d = {rx_q[WORD_W-2:0], miso};
      end else begin
        mosi_d = tx_q[WORD_W-1];
        tx_d   = tx_q << 1;
      end
      if (edge_q == last_edge) begin
        word_done = 1'b1;
        busy_d    = 1'b0;
        edge_d    = '0;
        if (last_q) ss_d = 1'b0;
      end else begin
        edge_d = edge_q + EC_W'(1);
      end
    end
    rx_word = rx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ss_q   <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      last_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      nb_q   <= NB_W'(WORD_W);
    end else begin
      busy_q <= busy_d;
      ss_q   <= ss_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      last_q <= last_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      edge_q <= edge_d;
      nb_q   <= nb_d;
    end
  end

  assign sck  = busy_q ? sck_q : cfg.cpol;
  assign mosi = mosi_q;
  assign ss_n = ~ss_q;
  assign busy = busy_q;

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  spi_cfg_t          cfg;
  logic [DIV_W-1:0]  brg;
  logic [LEN_W-1:0]  len_code;
  logic [WORD_W-1:0] tx_hold;
  logic              tx_full, eof, rx_full;
  logic              load_ack, eof_clr, word_done, busy, tick;
  logic [WORD_W-1:0] rx_word;
  logic              go;

  assign go = cfg.en && cfg.master;

  spi_fm_regs #(.WORD_W(WORD_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .load_ack  (load_ack),
    .eof_clr   (eof_clr),
    .word_done (word_done),
    .rx_word   (rx_word),
    .busy      (busy),
    .cfg       (cfg),
    .brg       (brg),
    .len_code  (len_code),
    .tx_hold   (tx_hold),
    .tx_full   (tx_full),
    .eof       (eof),
    .rx_full   (rx_full)
  );

  spi_fm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (busy),
    .brg   (brg),
    .tick  (tick)
  );

  spi_fm_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg       (cfg),
    .len_code  (len_code),
    .tx_hold   (tx_hold),
    .tx_full   (tx_full),
    .eof       (eof),
    .tick      (tick),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .ss_n      (ss_n),
    .busy      (busy),
    .load_ack  (load_ack),
    .eof_clr   (eof_clr),
    .word_done (word_done),
    .rx_word   (rx_word)
  );

endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk
  import spi_fm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              sck,
  input logic              ss_n,
  input logic              busy,
  input logic              tick,
  input logic              tx_full,
  input logic              rx_full,
  input logic              go,
  input logic              word_done
);

  // R8
  busy_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n);

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(bus_rd && (bus_addr == ADDR_W'(A_DATA))));

  // R6
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_full) |-> $past(bus_wr && (bus_addr == ADDR_W'(A_DATA))));

  // R11
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  // R2
  sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sck)) |-> $past(tick));

  // R10
  ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> $past(word_done || !go));

endmodule

bind spi_frame_master spi_fm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .sck       (sck),
  .ss_n      (ss_n),
  .busy      (busy),
  .tick      (tick),
  .tx_full   (tx_full),
  .rx_full   (rx_full),
  .go        (go),
  .word_done (word_done)
);

// File: tb/spi_frame_master_bench.sv
module spi_frame_master_bench;

  localparam int PERIOD = 10;
  localparam int NVEC   = 8;

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       sck, mosi, ss_n;

  int checks;
  int fails;

  // {mode[1:0], len[2:0], divider[15:0], data[7:0]}
  localparam logic [28:0] VECS [0:NVEC-1] = '{
    {2'd0, 3'd0, 16'd2, 8'hA5},
    {2'd1, 3'd0, 16'd1, 8'h3C},
    {2'd2, 3'd5, 16'd3, 8'hFF},
    {2'd3, 3'd1, 16'd2, 8'h01},
    {2'd0, 3'd7, 16'd0, 8'hD2},
    {2'd1, 3'd3, 16'd4, 8'hF6},
    {2'd2, 3'd0, 16'd1, 8'h81},
    {2'd3, 3'd4, 16'd5, 8'h9B}
  };

  spi_frame_master u_spi_frame_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sck       (sck),
    .mosi      (mosi),
    .miso      (mosi),
    .ss_n      (ss_n)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // serial-side monitor
  logic        tb_cpol, tb_cpha;
  int          mon_edges, mon_nbits, ss_rise;
  logic [31:0] mon_word;
  time         first_t, last_t;

  always @(posedge sck or negedge sck) begin
    mon_edges = mon_edges + 1;
    if (mon_edges == 1) first_t = $time;
    last_t = $time;
    if ((sck != tb_cpol) ^ tb_cpha) begin
      mon_word  = {mon_word[30:0], mosi};
      mon_nbits = mon_nbits + 1;
    end
  end

  always @(posedge ss_n) ss_rise = ss_rise + 1;

  task automatic mon_clear();
    mon_edges = 0;
    mon_nbits = 0;
    mon_word  = '0;
    first_t   = 0;
    last_t    = 0;
    ss_rise   = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic wait_stat(input int bitpos, input string req);
    logic [7:0] s;
    bit ok;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd3, s);
      if (s[bitpos]) begin
        ok = 1;
        break;
      end
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails = fails + 1;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    checks = 0;
    fails = 0;
    tb_cpol = 1'b0;
    tb_cpha = 1'b0;
    mon_clear();
    bus_addr = '0;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd3, r); chk("R1 status", 32'(r), 32'h01);
    rd(3'd1, r); chk("R1 control", 32'(r), 32'h00);
    rd(3'd2, r); chk("R1 length", 32'(r), 32'h00);
    chk("R1 ss_n", 32'(ss_n), 32'd1);
    chk("R1 sck", 32'(sck), 32'd0);

    // R11 gating: master only, then enable only
    wr(3'd4, 8'd1);
    wr(3'd5, 8'd0);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'h02);
    mon_clear();
    wr(3'd0, 8'h55);
    repeat (40) @(negedge clk);
    chk("R11 no edges master-only", 32'(mon_edges), 32'd0);
    chk("R11 ss_n idle", 32'(ss_n), 32'd1);
    rd(3'd3, r); chk("R6 R11 word held", 32'(r), 32'h00);
    wr(3'd1, 8'h01);
    repeat (40) @(negedge clk);
    chk("R11 no edges enable-only", 32'(mon_edges), 32'd0);
    wr(3'd1, 8'h13);
    wait_stat(1, "R7 rx full after enable");
    repeat (3) @(negedge clk);
    chk("R11 edges after enable", 32'(mon_edges), 32'd16);
    rd(3'd3, r); chk("R6 R7 status", 32'(r), 32'h03);
    rd(3'd0, r); chk("R11 data", 32'(r), 32'h55);

    // table of single-word frames
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  m;
      logic [2:0]  len;
      logic [15:0] div;
      logic [7:0]  d, msk, expv;
      int n, deff;
      m   = VECS[v][28:27];
      len = VECS[v][26:24];
      div = VECS[v][23:8];
      d   = VECS[v][7:0];
      n    = (len == 3'd0) ? 8 : int'(len);
      deff = (div == 16'd0) ? 1 : int'(div);
      msk  = 8'((9'd1 << n) - 9'd1);
      expv = d & msk;
      tb_cpol = m[1];
      tb_cpha = m[0];
      wr(3'd4, div[7:0]);
      wr(3'd5, div[15:8]);
      wr(3'd2, {5'd0, len});
      wr(3'd1, {3'b000, 1'b1, m[0], m[1], 2'b11});
      repeat (2) @(negedge clk);
      mon_clear();
      wr(3'd0, d);
      wait_stat(1, "R7 rx full");
      repeat (3) @(negedge clk);
      chk("R3 edge count", 32'(mon_edges), 32'(2 * n));
      chk("R5 msb-first bits", 32'(mon_word & {24'd0, msk}), 32'(expv));
      chk("R5 bit count", 32'(mon_nbits), 32'(n));
      chk("R2 edge span", 32'(last_t - first_t), 32'((2 * n - 1) * deff * PERIOD));
      chk("R4 sck rest", 32'(sck), 32'(m[1]));
      chk("R10 ss released", 32'(ss_n), 32'd1);
      rd(3'd0, r); chk("R4 R5 loopback data", 32'(r), 32'(expv));
      rd(3'd3, r); chk("R7 cleared by read", 32'(r), 32'h01);
      rd(3'd1, r); chk("R10 eof consumed", 32'(r), 32'({4'b0000, m[0], m[1], 2'b11}));
    end

    // R9 R10 two-word frame
    tb_cpol = 1'b0;
    tb_cpha = 1'b0;
    wr(3'd4, 8'd2);
    wr(3'd5, 8'd0);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'h03);
    repeat (2) @(negedge clk);
    mon_clear();
    wr(3'd0, 8'hC3);
    wait_stat(0, "R6 first word moved");
    chk("R9 ss asserted", 32'(ss_n), 32'd0);
    rd(3'd3, r); chk("R8 busy", 32'(r[2]), 32'd1);
    wr(3'd1, 8'h13);
    wr(3'd0, 8'h5A);
    begin
      bit done;
      done = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (ss_n) begin
          done = 1;
          break;
        end
      end
      chk("R10 frame ended", 32'(done), 32'd1);
    end
    repeat (3) @(negedge clk);
    chk("R9 single release", 32'(ss_rise), 32'd1);
    chk("R9 bits in frame", 32'(mon_nbits), 32'd16);
    chk("R9 frame data", mon_word & 32'h0000FFFF, 32'h0000C35A);
    rd(3'd0, r); chk("R7 last word", 32'(r), 32'h5A);
    rd(3'd1, r); chk("R10 eof cleared", 32'(r), 32'h03);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule